// File: doc/BRIEF.md
# Tiny 8-bit Multi-Cycle Processor Core

This block is a compact 8-bit processor core for control tasks that only move bytes, count, compare and branch. It fetches 16-bit instruction words from a word-wide instruction memory and exchanges bytes with a byte-wide data memory. Both memories have a synchronous read port, so the core presents an address in one cycle and uses the returned word or byte in the next. The data memory also takes a single-cycle write strobe. The core holds a 32-entry 8-bit register file and a program counter that counts instruction words. A five-flag status register is always visible on an output port, with bit 0 zero, bit 1 negative, bit 2 signed overflow, bit 3 carry/borrow and bit 4 half-carry/borrow.

The core runs eight operations: direct byte load, direct byte store, register compare, relative jump, branch on zero, branch on non-zero, increment and decrement. Each operation has a fixed cycle cost. A conditional branch costs one cycle more only when it is taken. A value wider than a byte moves as two byte transfers, with the low byte at the base address and the high byte at base+1. Loaded data goes into the register file while the following instruction executes. A bypass lets that instruction use the loaded value at once.

Top module: `tiny8_core`

## Requirements
- R1: A load (word `1001 000d dddd 0000` followed by a 16-bit address word) puts the byte at that data address into register d. It occupies 2 cycles, drives the address word onto `dmem_addr` in its second cycle, advances the PC by 2 and leaves all flags unchanged.
- R2: A store (word `1001 001r rrrr 0000` followed by a 16-bit address word) occupies 2 cycles and asserts `dmem_we` for exactly its second cycle, with the address word on `dmem_addr` and register r on `dmem_wdata`. It advances the PC by 2 and leaves all flags unchanged.
- R3: A compare (word `0001 01rd dddd rrrr`, r = bit 9 concatenated with bits 3..0) takes 1 cycle and writes no register. It sets the flags from d-r: zero if the 8-bit difference is 0, negative from bit 7 of the difference, overflow on signed overflow, carry if d < r unsigned, and half-carry if the low nibble of d is below that of r.
- R4: A relative jump (word `1100 kkkk kkkk kkkk`, k a 12-bit two's-complement offset) sets the PC to PC+k+1 and takes 2 cycles.
- R5: A branch (word `1111 0xkk kkkk k001`, k a 7-bit two's-complement offset) goes to PC+k+1 when x=0 and zero is set, or when x=1 and zero is clear. Otherwise it falls through to PC+1. A taken branch takes 2 cycles and an untaken one takes 1.
- R6: Increment (word `1001 010d dddd 0011`) and decrement (word `1001 010d dddd 1010`) update register d in 1 cycle. They set zero, negative and signed overflow from the result (overflow when 127 increments or 128 decrements) and leave carry and half-carry unchanged.
- R7: Any other instruction word runs as a 1-cycle no-operation that changes no register, flag or memory.
- R8: While reset is active and on its release, the status output is 0 and the fetch address is 0. The first instruction executed is the word at address 0.
- R9: A loaded value is usable by the instruction immediately after the load, including a store of the same register. If that instruction writes a different register in the same cycle, both writes take effect.
- R10: In every cycle `imem_addr` is the word address whose contents the core uses in the next cycle. After a jump or a taken branch, one refill cycle presents the target address again before the target executes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| imem_addr | output | PCW | Instruction word address |
| imem_rdata | input | 16 | Instruction word returned one cycle after its address |
| dmem_addr | output | DAW | Data byte address |
| dmem_rdata | input | DW | Data byte returned one cycle after its address |
| dmem_we | output | 1 | Data write strobe |
| dmem_wdata | output | DW | Data byte to write |
| stat_flags | output | 5 | Status flags: bit0 zero, bit1 negative, bit2 overflow, bit3 carry, bit4 half-carry |

## Verification
The bench targets the load that is used by the very next instruction, the load that coincides with an increment of a different register, and a store issued right after a load of the same register. A core without bypass or with a single write port would store stale data or lose one of the two writes. It also covers the overflow edges (127 incremented, 128 decremented, 255 wrapping to zero) and compares with borrow in the low nibble, where a wrong flag equation or clobbered carry/half-carry shows on the status port. Taken and untaken branches in both directions are compared cycle by cycle, along with a countdown loop and no-operation words that sit close to valid encodings. An off-by-one offset, a missing refill cycle or a mis-decoded word shifts the fetch trace or the stored bytes.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;

  localparam int NFLAGS = 5;
  localparam int FL_Z   = 0;
  localparam int FL_N   = 1;
  localparam int FL_V   = 2;
  localparam int FL_C   = 3;
  localparam int FL_H   = 4;

  localparam int IW     = 16;   // instruction word width
  localparam int RIDX_W = 5;    // register index width fixed by the encoding
  localparam int J_OFFW = 12;   // relative jump offset width
  localparam int B_OFFW = 7;    // conditional branch offset width

  typedef enum logic [1:0] {
    ST_FILL,   // refill: present PC, nothing executes
    ST_EXEC,   // first (or only) cycle of an instruction
    ST_LD2,    // second cycle of a load
    ST_ST2     // second cycle of a store
  } state_e;

  typedef enum logic [3:0] {
    OP_NOP,
    OP_LDS,
    OP_STS,
    OP_CP,
    OP_RJMP,
    OP_BREQ,
    OP_BRNE,
    OP_INC,
    OP_DEC
  } op_e;

  typedef enum logic [1:0] {
    ALU_CMP,
    ALU_INC,
    ALU_DEC
  } alu_op_e;

endpackage

// File: rtl/tiny8_decode.sv
module tiny8_decode
  import tiny8_pkg::*;
(
  input  logic [IW-1:0]     ir,
  output op_e               op,
  output logic [RIDX_W-1:0] rd_idx,
  output logic [RIDX_W-1:0] rr_idx,
  output logic [J_OFFW-1:0] joff,
  output logic [B_OFFW-1:0] boff
);

  assign rd_idx = ir[8:4];
  assign rr_idx = {ir[9], ir[3:0]};
  assign joff   = ir[11:0];
  assign boff   = ir[9:3];

  always_comb begin
    op = OP_NOP;
    if (ir[15:9] == 7'b1001000 && ir[3:0] == 4'h0)      op = OP_LDS;
    else if (ir[15:9] == 7'b1001001 && ir[3:0] == 4'h0) op = OP_STS;
    else if (ir[15:9] == 7'b1001010 && ir[3:0] == 4'h3) op = OP_INC;
    else if (ir[15:9] == 7'b1001010 && ir[3:0] == 4'hA) op = OP_DEC;
    else if (ir[15:10] == 6'b000101)                    op = OP_CP;
    else if (ir[15:12] == 4'hC)                         op = OP_RJMP;
    else if (ir[15:11] == 5'b11110 && ir[2:0] == 3'b001)
      op = ir[10] ? OP_BRNE : OP_BREQ;
  end

endmodule

// File: rtl/tiny8_alu.sv
module tiny8_alu
  import tiny8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e           op,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  output logic [DW-1:0]     res,
  output logic [NFLAGS-1:0] fl_new,
  output logic [NFLAGS-1:0] fl_mask
);

  localparam int HW = DW / 2;

  logic [DW:0] diff;
  logic [HW:0] hdiff;

  assign diff  = {1'b0, a} - {1'b0, b};
  assign hdiff = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]};

  always_comb begin
    res     = diff[DW-1:0];
    fl_new  = '0;
    fl_mask = '0;
    unique case (op)
      ALU_CMP: begin
        res           = diff[DW-1:0];
        fl_new[FL_C]  = diff[DW];
        fl_new[FL_H]  = hdiff[HW];
        fl_new[FL_V]  = (a[DW-1] ^ b[DW-1]) & (a[DW-1] ^ res[DW-1]);
        fl_mask       = '1;
      end
      ALU_INC: begin
        res           = a + DW'(1);
        fl_new[FL_V]  = res[DW-1] & ~a[DW-1];
        fl_mask[FL_Z] = 1'b1;
        fl_mask[FL_N] = 1'b1;
        fl_mask[FL_V] = 1'b1;
      end
      ALU_DEC: begin
        res           = a - DW'(1);
        fl_new[FL_V]  = ~res[DW-1] & a[DW-1];
        fl_mask[FL_Z] = 1'b1;
        fl_mask[FL_N] = 1'b1;
        fl_mask[FL_V] = 1'b1;
      end
      default: begin
        res     = diff[DW-1:0];
        fl_mask = '0;
      end
    endcase
    fl_new[FL_Z] = (res == '0);
    fl_new[FL_N] = res[DW-1];
  end

endmodule

// File: rtl/tiny8_regfile.sv
module tiny8_regfile #(
  parameter int DW    = 8,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  // port A: execution result, wins on an index clash
  input  logic          wa_en,
  input  logic [AW-1:0] wa_idx,
  input  logic [DW-1:0] wa_data,
  // port B: deferred load data
  input  logic          wb_en,
  input  logic [AW-1:0] wb_idx,
  input  logic [DW-1:0] wb_data,
  input  logic [AW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_idx,
  output logic [DW-1:0] rb_data
);

  logic [DW-1:0] regs [NREGS];

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_entry
    logic hit_a, hit_b;
    assign hit_a = wa_en && (wa_idx == AW'(gi));
    assign hit_b = wb_en && (wb_idx == AW'(gi));
    always_ff @(posedge clk) begin
      if (hit_a)      regs[gi] <= wa_data;
      else if (hit_b) regs[gi] <= wb_data;
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];

endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
  import tiny8_pkg::*;
#(
  parameter int PCW = 16,
  parameter int DAW = 16,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PCW-1:0]    imem_addr,
  input  logic [IW-1:0]     imem_rdata,
  output logic [DAW-1:0]    dmem_addr,
  input  logic [DW-1:0]     dmem_rdata,
  output logic              dmem_we,
  output logic [DW-1:0]     dmem_wdata,
  output logic [NFLAGS-1:0] stat_flags
);

  localparam int NREGS = 1 << RIDX_W;

  // architectural and sequencing state
  state_e              state_q, state_d;
  logic [PCW-1:0]      pc_q, pc_d;
  logic                pc_en;
  logic [NFLAGS-1:0]   flags_q, flags_d;
  logic                flags_en;
  logic [RIDX_W-1:0]   opr_q;        // register of the pending two-word op
  logic                opr_en;
  logic                ldp_q, ldp_d; // load data arrives this cycle

  // decode
  op_e                 dec_op;
  logic [RIDX_W-1:0]   dec_rd, dec_rr;
  logic [J_OFFW-1:0]   dec_joff;
  logic [B_OFFW-1:0]   dec_boff;

  tiny8_decode u_decode (
    .ir     (imem_rdata),
    .op     (dec_op),
    .rd_idx (dec_rd),
    .rr_idx (dec_rr),
    .joff   (dec_joff),
    .boff   (dec_boff)
  );

  // register file with load bypass
  logic [RIDX_W-1:0] rb_sel;
  logic [DW-1:0]     ra_raw, rb_raw, opa, opb;
  logic              rf_wa_en;
  logic [DW-1:0]     alu_res;

  assign rb_sel = (state_q == ST_ST2) ? opr_q : dec_rr;

  tiny8_regfile #(.DW(DW), .NREGS(NREGS)) u_regfile (
    .clk     (clk),
    .wa_en   (rf_wa_en),
    .wa_idx  (dec_rd),
    .wa_data (alu_res),
    .wb_en   (ldp_q),
    .wb_idx  (opr_q),
    .wb_data (dmem_rdata),
    .ra_idx  (dec_rd),
    .ra_data (ra_raw),
    .rb_idx  (rb_sel),
    .rb_data (rb_raw)
  );

  assign opa = (ldp_q && opr_q == dec_rd) ? dmem_rdata : ra_raw;
  assign opb = (ldp_q && opr_q == rb_sel) ? dmem_rdata : rb_raw;

  // ALU
  alu_op_e           alu_op;
  logic [NFLAGS-1:0] fl_new, fl_mask;

  always_comb begin
    unique case (dec_op)
      OP_INC:  alu_op = ALU_INC;
      OP_DEC:  alu_op = ALU_DEC;
      default: alu_op = ALU_CMP;
    endcase
  end

  tiny8_alu #(.DW(DW)) u_alu (
    .op      (alu_op),
    .a       (opa),
    .b       (opb),
    .res     (alu_res),
    .fl_new  (fl_new),
    .fl_mask (fl_mask)
  );

  logic in_exec, is_alu;
  assign in_exec  = (state_q == ST_EXEC);
  assign is_alu   = (dec_op == OP_CP) || (dec_op == OP_INC) || (dec_op == OP_DEC);
  assign rf_wa_en = in_exec && (dec_op == OP_INC || dec_op == OP_DEC);
  assign flags_en = in_exec && is_alu;
  assign flags_d  = (flags_q & ~fl_mask) | (fl_new & fl_mask);

  // control-flow targets
  logic [PCW-1:0] pc_p1, pc_p2, tgt_j, tgt_b;
  logic           br_take;

  assign pc_p1   = pc_q + PCW'(1);
  assign pc_p2   = pc_q + PCW'(2);
  assign tgt_j   = pc_p1 + {{(PCW-J_OFFW){dec_joff[J_OFFW-1]}}, dec_joff};
  assign tgt_b   = pc_p1 + {{(PCW-B_OFFW){dec_boff[B_OFFW-1]}}, dec_boff};
  assign br_take = (dec_op == OP_BREQ &&  flags_q[FL_Z]) ||
                   (dec_op == OP_BRNE && ~flags_q[FL_Z]);

  // next-state logic
  logic [PCW-1:0] fetch;

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    pc_en   = 1'b0;
    opr_en  = 1'b0;
    fetch   = pc_q;
    ldp_d   = (state_q == ST_LD2);
    unique case (state_q)
      ST_FILL: begin
        fetch   = pc_q;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        unique case (dec_op)
          OP_LDS, OP_STS: begin
            fetch   = pc_p1;
            opr_en  = 1'b1;
            state_d = (dec_op == OP_LDS) ? ST_LD2 : ST_ST2;
          end
          OP_RJMP: begin
            pc_d    = tgt_j;
            pc_en   = 1'b1;
            fetch   = tgt_j;
            state_d = ST_FILL;
          end
          OP_BREQ, OP_BRNE: begin
            pc_en = 1'b1;
            if (br_take) begin
              pc_d    = tgt_b;
              fetch   = tgt_b;
              state_d = ST_FILL;
            end else begin
              pc_d  = pc_p1;
              fetch = pc_p1;
            end
          end
          default: begin
            pc_d  = pc_p1;
            pc_en = 1'b1;
            fetch = pc_p1;
          end
        endcase
      end
      ST_LD2, ST_ST2: begin
        pc_d    = pc_p2;
        pc_en   = 1'b1;
        fetch   = pc_p2;
        state_d = ST_EXEC;
      end
      default: begin
        state_d = ST_FILL;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      pc_q    <= '0;
      flags_q <= '0;
      ldp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ldp_q   <= ldp_d;
      if (pc_en)    pc_q    <= pc_d;
      if (flags_en) flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk) begin
    if (opr_en) opr_q <= dec_rd;
  end

  // outputs
  assign imem_addr  = fetch;
  assign dmem_addr  = imem_rdata[DAW-1:0];
  assign dmem_we    = (state_q == ST_ST2);
  assign dmem_wdata = opb;
  assign stat_flags = flags_q;

endmodule

// File: rtl/tiny8_core_chk.sv
module tiny8_core_chk
  import tiny8_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input state_e            state,
  input op_e               op,
  input logic [NFLAGS-1:0] flags,
  input logic              we,
  input logic              ld_pend
);

  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we); // R2

  AST_MEMOP_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LD2 || state == ST_ST2) |=> $stable(flags)); // R1

  AST_REFILL_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL) |=> (state == ST_EXEC)); // R4

  AST_INCDEC_KEEP_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && (op == OP_INC || op == OP_DEC))
      |=> $stable(flags[FL_H:FL_C])); // R6

  AST_LOAD_LANDS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LD2) |=> (state == ST_EXEC && ld_pend)); // R9

  AST_NOP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && op == OP_NOP) |=> ($stable(flags) && state == ST_EXEC && !we)); // R7

endmodule

bind tiny8_core tiny8_core_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .state   (state_q),
  .op      (dec_op),
  .flags   (stat_flags),
  .we      (dmem_we),
  .ld_pend (ldp_q)
);

// File: tb/tiny8_core_bench.sv
module tiny8_core_bench;

  localparam int PCW = 16;
  localparam int DAW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;   // 100 MHz

  logic           rst_n;
  logic [PCW-1:0] imem_addr;
  logic [15:0]    imem_rdata;
  logic [DAW-1:0] dmem_addr;
  logic [7:0]     dmem_rdata;
  logic           dmem_we;
  logic [7:0]     dmem_wdata;
  logic [4:0]     stat_flags;

  tiny8_core #(.PCW(PCW), .DAW(DAW), .DW(8)) u_tiny8_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_rdata (dmem_rdata),
    .dmem_we    (dmem_we),
    .dmem_wdata (dmem_wdata),
    .stat_flags (stat_flags)
  );

  // memories with synchronous read
  logic [15:0] imem [64];
  logic [7:0]  dmem [256];

  always @(posedge clk) begin
    imem_rdata <= imem[imem_addr[5:0]];
    dmem_rdata <= dmem[dmem_addr[7:0]];
    if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
  end

  int  n_chk = 0;
  int  n_err = 0;
  bit  chk_en = 1'b0;
  bit  done = 1'b0;

  task automatic check(input bit ok, input int req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // encoders
  function automatic logic [15:0] e_lds(input logic [4:0] d);  return {7'b1001000, d, 4'h0}; endfunction
  function automatic logic [15:0] e_sts(input logic [4:0] r);  return {7'b1001001, r, 4'h0}; endfunction
  function automatic logic [15:0] e_cp(input logic [4:0] d, input logic [4:0] r);
    return {6'b000101, r[4], d, r[3:0]};
  endfunction
  function automatic logic [15:0] e_rjmp(input int k);  return {4'hC, 12'(k)}; endfunction
  function automatic logic [15:0] e_breq(input int k);  return {6'b111100, 7'(k), 3'b001}; endfunction
  function automatic logic [15:0] e_brne(input int k);  return {6'b111101, 7'(k), 3'b001}; endfunction
  function automatic logic [15:0] e_inc(input logic [4:0] d)  ; return {7'b1001010, d, 4'h3}; endfunction
  function automatic logic [15:0] e_dec(input logic [4:0] d)  ; return {7'b1001010, d, 4'hA}; endfunction

  int pp = 0;
  task automatic emit(input logic [15:0] w);
    imem[pp] = w;
    pp++;
  endtask

  // behavioural reference model
  typedef struct {
    logic [15:0] ia;
    bit          acc;
    bit          we;
    logic [15:0] da;
    logic [7:0]  wd;
    logic [4:0]  fl;
    int          req;
  } exp_t;

  exp_t        q[$];
  int          mpc;
  logic [7:0]  mr [32];
  logic [7:0]  md [256];
  logic [4:0]  mf;

  task automatic push(input int ia, input bit acc, input bit we,
                      input logic [15:0] da, input logic [7:0] wd, input int req);
    exp_t e;
    e.ia = 16'(ia); e.acc = acc; e.we = we; e.da = da; e.wd = wd; e.fl = mf; e.req = req;
    q.push_back(e);
  endtask

  function automatic int sgn8(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  task automatic model_step();
    logic [15:0] w, aw;
    logic [4:0]  rd, rs;
    int a, b, r, k, t, sd;
    w  = imem[mpc[5:0]];
    aw = imem[6'(mpc + 1)];
    rd = w[8:4];
    rs = {w[9], w[3:0]};
    if (w[15:9] == 7'b1001000 && w[3:0] == 4'h0) begin          // R1 load
      push(mpc + 1, 0, 0, 16'h0, 8'h0, 1);
      push(mpc + 2, 1, 0, aw, 8'h0, 1);
      mr[rd] = md[aw[7:0]];
      mpc = (mpc + 2) & 16'hFFFF;
    end else if (w[15:9] == 7'b1001001 && w[3:0] == 4'h0) begin // R2 store
      push(mpc + 1, 0, 0, 16'h0, 8'h0, 2);
      push(mpc + 2, 1, 1, aw, mr[rd], 2);
      md[aw[7:0]] = mr[rd];
      mpc = (mpc + 2) & 16'hFFFF;
    end else if (w[15:9] == 7'b1001010 && (w[3:0] == 4'h3 || w[3:0] == 4'hA)) begin // R6
      push(mpc + 1, 0, 0, 16'h0, 8'h0, 6);
      a = int'(mr[rd]);
      if (w[3:0] == 4'h3) begin
        r  = (a + 1) & 255;
        sd = sgn8(a) + 1;
      end else begin
        r  = (a + 255) & 255;
        sd = sgn8(a) - 1;
      end
      mf[0] = (r == 0);
      mf[1] = (r >= 128);
      mf[2] = (sd > 127) || (sd < -128);
      mr[rd] = 8'(r);
      mpc = (mpc + 1) & 16'hFFFF;
    end else if (w[15:10] == 6'b000101) begin                    // R3 compare
      push(mpc + 1, 0, 0, 16'h0, 8'h0, 3);
      a  = int'(mr[rd]);
      b  = int'(mr[rs]);
      r  = (a - b) & 255;
      sd = sgn8(a) - sgn8(b);
      mf = {((a & 15) < (b & 15)), (a < b), ((sd > 127) || (sd < -128)), (r >= 128), (r == 0)};
      mpc = (mpc + 1) & 16'hFFFF;
    end else if (w[15:12] == 4'hC) begin                         // R4 jump
      k = int'(w[11:0]);
      if (k >= 2048) k -= 4096;
      t = (mpc + 1 + k) & 16'hFFFF;
      push(t, 0, 0, 16'h0, 8'h0, 4);
      push(t, 0, 0, 16'h0, 8'h0, 4);
      mpc = t;
    end else if (w[15:11] == 5'b11110 && w[2:0] == 3'b001) begin // R5 branch
      k = int'(w[9:3]);
      if (k >= 64) k -= 128;
      t = (mpc + 1 + k) & 16'hFFFF;
      if (w[10] ? !mf[0] : mf[0]) begin
        push(t, 0, 0, 16'h0, 8'h0, 5);
        push(t, 0, 0, 16'h0, 8'h0, 5);
        mpc = t;
      end else begin
        push(mpc + 1, 0, 0, 16'h0, 8'h0, 5);
        mpc = (mpc + 1) & 16'hFFFF;
      end
    end else begin                                               // R7 no-operation
      push(mpc + 1, 0, 0, 16'h0, 8'h0, 7);
      mpc = (mpc + 1) & 16'hFFFF;
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin : cmp
    exp_t e;
    if (chk_en) begin
      if (q.size() == 0) model_step();
      e = q.pop_front();
      // R10: fetch address trace
      check(imem_addr === e.ia[PCW-1:0], 10, $sformatf("fetch address (instr R%0d)", e.req), 16'(imem_addr), e.ia);
      check(dmem_we === e.we, e.req, "write strobe", 16'(dmem_we), 16'(e.we));
      if (e.acc) check(dmem_addr === e.da, e.req, "data address", dmem_addr, e.da);
      if (e.we)  check(dmem_wdata === e.wd, e.req, "write data", 16'(dmem_wdata), 16'(e.wd));
      check(stat_flags === e.fl, e.req, "status flags", 16'(stat_flags), 16'(e.fl));
    end
  end

  task automatic set_data(input int a, input logic [7:0] v);
    dmem[a] <= v;
    md[a] = v;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) imem[i] = 16'h0000;
    for (int i = 0; i < 256; i++) set_data(i, 8'h00);
    set_data(8'h10, 8'h7F);
    set_data(8'h11, 8'h80);
    set_data(8'h12, 8'hFF);
    set_data(8'h14, 8'h05);
    set_data(8'h15, 8'h03);
    set_data(8'h20, 8'h34);
    set_data(8'h21, 8'h12);

    emit(e_lds(16)); emit(16'h0010);   // R9: load then use at once
    emit(e_inc(16));                   // R6: 7F -> 80, overflow
    emit(e_lds(17)); emit(16'h0011);
    emit(e_dec(17));                   // R6: 80 -> 7F, overflow
    emit(e_lds(18)); emit(16'h0012);
    emit(e_inc(18));                   // R6: FF -> 00, zero
    emit(e_lds(19)); emit(16'h0014);
    emit(e_lds(20)); emit(16'h0015);
    emit(e_cp(19, 20));                // R3: 5-3
    emit(e_cp(20, 19));                // R3: 3-5, borrow and half borrow
    emit(e_breq(5));                   // R5: not taken
    emit(e_brne(1));                   // R5: taken forward
    emit(e_inc(16));                   // skipped
    emit(e_cp(16, 16));                // R3: equal
    emit(e_brne(3));                   // R5: not taken
    emit(e_breq(1));                   // R5: taken
    emit(e_dec(16));                   // skipped
    emit(16'h0000);                    // R7: unrecognised word
    emit(16'h9405);                    // R7: near an increment encoding
    emit(e_sts(16)); emit(16'h0030);
    emit(e_sts(17)); emit(16'h0031);
    emit(e_sts(18)); emit(16'h0032);
    emit(e_lds(24)); emit(16'h0020);   // 16-bit move, low byte
    emit(e_lds(25)); emit(16'h0021);   // high byte
    emit(e_sts(25)); emit(16'h0041);
    emit(e_sts(24)); emit(16'h0040);
    emit(e_lds(5));  emit(16'h0014);   // R9: load lands while another reg is written
    emit(e_inc(19));
    emit(e_sts(5));  emit(16'h0033);
    emit(e_sts(19)); emit(16'h0034);
    emit(e_lds(7));  emit(16'h0015);   // R9: store right after load
    emit(e_sts(7));  emit(16'h0035);
    emit(e_lds(9));  emit(16'h0015);
    emit(e_dec(9));                    // loop body
    emit(e_brne(-2));                  // R5: taken backward
    emit(e_sts(9));  emit(16'h0036);
    emit(e_rjmp(1));                   // R4: forward jump
    emit(e_inc(9));                    // skipped
    emit(e_rjmp(-1));                  // R4: self loop

    mpc = 0;
    mf  = 5'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(stat_flags === 5'b0, 8, "flags in reset", 16'(stat_flags), 16'h0);        // R8
    check(imem_addr === '0, 8, "fetch address in reset", 16'(imem_addr), 16'h0);    // R8
    repeat (2) @(posedge clk);
    #2;
    rst_n = 1'b1;
    push(0, 0, 0, 16'h0, 8'h0, 8);     // R8: refill of address 0 after release
    chk_en = 1'b1;
    repeat (300) @(posedge clk);
    #2;
    chk_en = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    check(dmem[8'h30] === 8'h80, 6, "inc result", 16'(dmem[8'h30]), 16'h80);       // R6
    check(dmem[8'h31] === 8'h7F, 6, "dec result", 16'(dmem[8'h31]), 16'h7F);       // R6
    check(dmem[8'h32] === 8'h00, 6, "inc wrap", 16'(dmem[8'h32]), 16'h00);         // R6
    check(dmem[8'h33] === 8'h05, 9, "load beside write", 16'(dmem[8'h33]), 16'h05); // R9
    check(dmem[8'h34] === 8'h06, 9, "write beside load", 16'(dmem[8'h34]), 16'h06); // R9
    check(dmem[8'h35] === 8'h03, 9, "store after load", 16'(dmem[8'h35]), 16'h03);  // R9
    check(dmem[8'h36] === 8'h00, 5, "loop count", 16'(dmem[8'h36]), 16'h00);       // R5
    check(dmem[8'h40] === 8'h34, 1, "move low byte", 16'(dmem[8'h40]), 16'h34);    // R1
    check(dmem[8'h41] === 8'h12, 2, "move high byte", 16'(dmem[8'h41]), 16'h12);   // R2
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule